// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 16-bit bidirectional buses, A and B. It holds a separate storage register for each direction of flow. Traffic from A to B passes through the forward store, and traffic from B to A passes through the reverse store. The 16 bits form two bytes, and each byte has its own three control lines per direction, all active low:

- a gate (`*_gate_n`) that enables the byte for that direction;
- a capture line (`*_cap_n`) that selects between following the source and holding;
- a drive line (`*_drv_n`) that enables the output buffer.

Tie the two bytes' controls together and the block acts as one 16-bit transceiver.

The block is synchronous. The storage of each byte and direction updates on the rising edge of `clk`. A gated, capturing store follows its source port with a delay of one edge. When the capture line rises, the store keeps the last value it loaded. The output buffers are tri-state and combinational from the store and the control lines. The surrounding logic must never let the block and an external agent drive the same byte of the same port at once.

The interfaces are plain tri-state buses, so they carry no valid/ready handshake and offer no back-pressure. A destination byte is valid whenever its gate and drive lines are both low, and it is high impedance otherwise.

Top module: `lt_bus_xcvr`

## Requirements
- R1: After reset every store holds zero. With all control lines high, neither port is driven by the block.
- R2: When a byte's gate and capture lines for a direction are both low at a rising clock edge, that byte's store loads the source port byte. For A-to-B the source is `port_a`; for B-to-A it is `port_b`.
- R3: When the gate is low and the capture line is high at a rising edge, the store keeps its value. After a low-to-high change of the capture line, the store keeps the value loaded at the last edge with the capture line low.
- R4: When a byte's gate line for a direction is high, that byte's store keeps its value whatever the capture line does, and the destination byte is high impedance whatever the drive line does.
- R5: The destination byte carries the store contents exactly when the gate and drive lines are both low, and is high impedance otherwise.
- R6: Byte n, where n is 0 or 1, occupies bits [8n+7:8n] of both ports and of the stores. It is governed only by bit n of each control vector and affects no other byte.
- R7: The B-to-A direction behaves as the A-to-B direction with the roles of the ports exchanged. The two stores are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears both stores |
| ab_gate_n | input | 2 | A-to-B gate per byte, active low |
| ab_cap_n | input | 2 | A-to-B capture line per byte; low follows the source, high holds |
| ab_drv_n | input | 2 | A-to-B output drive per byte, active low |
| ba_gate_n | input | 2 | B-to-A gate per byte, active low |
| ba_cap_n | input | 2 | B-to-A capture line per byte; low follows the source, high holds |
| ba_drv_n | input | 2 | B-to-A output drive per byte, active low |
| port_a | inout | 16 | Bus A: source for A-to-B, destination for B-to-A |
| port_b | inout | 16 | Bus B: source for B-to-A, destination for A-to-B |

## Verification
A load into a store is due at the first rising edge after the gate and capture lines go low with the source driven. The bench therefore changes inputs on a falling edge and reads the destination at the next falling edge, one rising edge later. Drive and high-impedance results follow a control change with no clock delay, so the bench reads them a nanosecond after it changes the controls. Whether a store held or loaded is read back in a later step, with the capture line high and the drive enabled. Each port has a pull-up, so an undriven byte reads 8'hFF, and the stored patterns never equal 8'hFF.

// File: rtl/lt_xcvr_pkg.sv
package lt_xcvr_pkg;

  // Per-byte, per-direction control bundle (all active low at the pins).
  typedef struct packed {
    logic gate_n;
    logic cap_n;
    logic drv_n;
  } lane_ctl_t;

  // Decoded intent for one byte of one direction.
  typedef struct packed {
    logic load;
    logic drive;
  } lane_act_t;

  function automatic lane_act_t decode_lane(input lane_ctl_t c);
    lane_act_t a;
    a.load  = !c.gate_n && !c.cap_n;
    a.drive = !c.gate_n && !c.drv_n;
    return a;
  endfunction

endpackage

// File: rtl/lt_lane_decode.sv
module lt_lane_decode
  import lt_xcvr_pkg::*;
(
  input  logic gate_n,
  input  logic cap_n,
  input  logic drv_n,
  output logic load,
  output logic drive
);

  lane_ctl_t ctl;
  lane_act_t act;

  always_comb begin
    ctl.gate_n = gate_n;
    ctl.cap_n  = cap_n;
    ctl.drv_n  = drv_n;
    act        = decode_lane(ctl);
  end

  assign load  = act.load;
  assign drive = act.drive;

endmodule

// File: rtl/lt_byte_store.sv
module lt_byte_store #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));                                     // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));                                           // R3

endmodule

// File: rtl/lt_dir_path.sv
module lt_dir_path #(
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] gate_n,
  input  logic [NBYTES-1:0] cap_n,
  input  logic [NBYTES-1:0] drv_n,
  input  logic [W-1:0]      src,
  output logic [W-1:0]      q,
  output logic [NBYTES-1:0] drive
);

  logic [NBYTES-1:0] load;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    lt_lane_decode u_dec (
      .gate_n (gate_n[i]),
      .cap_n  (cap_n[i]),
      .drv_n  (drv_n[i]),
      .load   (load[i]),
      .drive  (drive[i])
    );

    lt_byte_store #(.BYTE_W(BYTE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load[i]),
      .din   (src[i*BYTE_W +: BYTE_W]),
      .q     (q[i*BYTE_W +: BYTE_W])
    );

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      gate_n[i] |=> $stable(q[i*BYTE_W +: BYTE_W]));                 // R4
    AST_GATE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      gate_n[i] |-> !drive[i]);                                      // R4
  end

endmodule

// File: rtl/lt_bus_xcvr.sv
module lt_bus_xcvr #(
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] ab_gate_n,
  input  logic [NBYTES-1:0] ab_cap_n,
  input  logic [NBYTES-1:0] ab_drv_n,
  input  logic [NBYTES-1:0] ba_gate_n,
  input  logic [NBYTES-1:0] ba_cap_n,
  input  logic [NBYTES-1:0] ba_drv_n,
  inout  wire  [W-1:0]      port_a,
  inout  wire  [W-1:0]      port_b
);

  logic [W-1:0]      q_ab;
  logic [W-1:0]      q_ba;
  logic [NBYTES-1:0] drv_ab;
  logic [NBYTES-1:0] drv_ba;

  lt_dir_path #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_fwd (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_n (ab_gate_n),
    .cap_n  (ab_cap_n),
    .drv_n  (ab_drv_n),
    .src    (port_a),
    .q      (q_ab),
    .drive  (drv_ab)
  );

  lt_dir_path #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rev (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_n (ba_gate_n),
    .cap_n  (ba_cap_n),
    .drv_n  (ba_drv_n),
    .src    (port_b),
    .q      (q_ba),
    .drive  (drv_ba)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_out
    assign port_b[i*BYTE_W +: BYTE_W] = drv_ab[i] ? q_ab[i*BYTE_W +: BYTE_W] : {BYTE_W{1'bz}};
    assign port_a[i*BYTE_W +: BYTE_W] = drv_ba[i] ? q_ba[i*BYTE_W +: BYTE_W] : {BYTE_W{1'bz}};

    AST_FWD_DRIVES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_gate_n[i] && !ab_drv_n[i]) |-> (port_b[i*BYTE_W +: BYTE_W] == q_ab[i*BYTE_W +: BYTE_W])); // R5
    AST_REV_DRIVES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_gate_n[i] && !ba_drv_n[i]) |-> (port_a[i*BYTE_W +: BYTE_W] == q_ba[i*BYTE_W +: BYTE_W])); // R7
  end

endmodule

// File: tb/tb_lt_bus_xcvr.sv
module tb_lt_bus_xcvr;

  localparam int NB = 2;
  localparam int BW = 8;
  localparam int W  = NB * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] ab_gate_n = '1, ab_cap_n = '1, ab_drv_n = '1;
  logic [NB-1:0] ba_gate_n = '1, ba_cap_n = '1, ba_drv_n = '1;
  logic [W-1:0]  a_drv = '0, b_drv = '0;
  logic [NB-1:0] a_en = '0, b_en = '0;
  wire  [W-1:0]  port_a;
  wire  [W-1:0]  port_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NB; i++) begin : g_tbdrv
    assign port_a[i*BW +: BW] = a_en[i] ? a_drv[i*BW +: BW] : {BW{1'bz}};
    assign port_b[i*BW +: BW] = b_en[i] ? b_drv[i*BW +: BW] : {BW{1'bz}};
  end
  for (genvar k = 0; k < W; k++) begin : g_pull
    pullup (port_a[k]);
    pullup (port_b[k]);
  end

  lt_bus_xcvr #(.NBYTES(NB), .BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_gate_n(ab_gate_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
    .ba_gate_n(ba_gate_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n),
    .port_a(port_a), .port_b(port_b)
  );

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Guards against the bench and the block driving the same byte at once.
  task automatic guard_contention();
    for (int n = 0; n < NB; n++) begin
      if (a_en[n] && !ba_gate_n[n] && !ba_drv_n[n])
        $display("WARN illegal configuration on port A byte %0d", n);
      if (b_en[n] && !ab_gate_n[n] && !ab_drv_n[n])
        $display("WARN illegal configuration on port B byte %0d", n);
    end
  endtask

  task automatic all_idle();
    ab_gate_n = '1; ab_cap_n = '1; ab_drv_n = '1;
    ba_gate_n = '1; ba_cap_n = '1; ba_drv_n = '1;
    a_en = '0; b_en = '0;
  endtask

  task automatic set_ctl(input bit dir, input int n, input bit g, input bit c, input bit d);
    if (!dir) begin ab_gate_n[n] = g; ab_cap_n[n] = c; ab_drv_n[n] = d; end
    else      begin ba_gate_n[n] = g; ba_cap_n[n] = c; ba_drv_n[n] = d; end
  endtask

  task automatic drive_src(input bit dir, input int n, input logic [BW-1:0] v);
    if (!dir) begin a_drv[n*BW +: BW] = v; a_en[n] = 1'b1; end
    else      begin b_drv[n*BW +: BW] = v; b_en[n] = 1'b1; end
  endtask

  function automatic logic [BW-1:0] dest_byte(input bit dir, input int n);
    return dir ? port_a[n*BW +: BW] : port_b[n*BW +: BW];
  endfunction

  // dir 0: A-to-B (R2..R6); dir 1: B-to-A (R7). combo bits: gate, cap, drv.
  task automatic run_case(input bit dir, input int n, input int combo);
    logic [BW-1:0] p0, p1, exp_store, exp_dest;
    bit g, c, d;
    int o;
    g = combo[2]; c = combo[1]; d = combo[0];
    o = 1 - n;
    p0 = 8'(8'h11 * (combo + 1)) ^ 8'(n * 8'h40) ^ 8'(dir ? 8'h20 : 8'h00);
    p1 = p0 ^ 8'h0F;
    @(negedge clk);
    all_idle();
    drive_src(dir, n, p0);
    set_ctl(dir, n, 1'b0, 1'b0, 1'b1);
    guard_contention();
    @(negedge clk);
    set_ctl(dir, n, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    set_ctl(dir, n, g, c, d);
    drive_src(dir, n, p1);
    guard_contention();
    @(negedge clk);
    exp_store = (!g && !c) ? p1 : p0;
    exp_dest  = (!g && !d) ? exp_store : 8'hFF;
    check(dir ? "R7 dest byte" : (g ? "R4 dest byte" : "R5 dest byte"),
          dest_byte(dir, n), exp_dest);
    check("R6 other byte undriven", dest_byte(dir, o), 8'hFF);
    all_idle();
    set_ctl(dir, n, 1'b0, 1'b1, 1'b0);
    #1;
    check(dir ? "R7 store" : (!g && !c ? "R2 store" : (g ? "R4 store" : "R3 store")),
          dest_byte(dir, n), exp_store);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle controls leave both ports undriven (pulled up)
    check("R1 port_a idle", port_a[7:0], 8'hFF);
    check("R1 port_a idle", port_a[15:8], 8'hFF);
    check("R1 port_b idle", port_b[7:0], 8'hFF);
    check("R1 port_b idle", port_b[15:8], 8'hFF);
    // R1: stores cleared by reset
    ab_gate_n = '0; ab_drv_n = '0; ba_gate_n = '0; ba_drv_n = '0;
    #1;
    check("R1 fwd store zero", port_b[7:0], 8'h00);
    check("R1 fwd store zero", port_b[15:8], 8'h00);
    check("R1 rev store zero", port_a[7:0], 8'h00);
    check("R1 rev store zero", port_a[15:8], 8'h00);
    for (int dir = 0; dir < 2; dir++)
      for (int n = 0; n < NB; n++)
        for (int combo = 0; combo < 8; combo++)
          run_case(dir[0], n, combo);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule